// File: doc/BRIEF.md
# Multicycle RISC Datapath

This block is the datapath half of a 32-bit processor that spends several clock cycles on each instruction. A single memory port serves both instruction fetch and data access. A single ALU computes the PC increment, branch targets, memory addresses and arithmetic results, so the block has no separate adders. Hidden registers carry each cycle's results into later cycles of the same instruction: the instruction latch, the memory data latch, the two operand latches and the ALU result latch. The register file and the program counter are also inside the block. Only the instruction latch and the PC have write enables. The other hidden registers load on every clock.

The block contains no sequencer. A separate controller drives the step-by-step control inputs, and the block returns the opcode field, the function field and the ALU zero flag so that the controller can decide the next step. Memory sits outside the block. Its read data must be valid in the same cycle as the address, and writes happen on the clock edge while `mem_we` is high. Register-to-register ALU operations, word load, word store, branch-if-equal and jump can all be built from the control inputs.

Top module: `mc_datapath`

## Requirements
- R1: After reset the PC and all hidden registers are zero. With every control input low, this gives `mem_addr`=0, `opcode`=0, `funct`=0, `mem_wdata`=0, `mem_we`=0 and `zero`=1.
- R2: When `ir_write`=1, the instruction latch captures `mem_rdata` at the clock edge. `opcode` shows bits 31:26 of that latch and `funct` shows bits 5:0. When `ir_write`=0 the latch holds its value.
- R3: `mem_addr` equals the PC when `i_or_d`=0. The settings `alu_src_a`=0, `alu_src_b`=1 (constant 4), `alu_fn`=010 (add), `pc_source`=0 (raw ALU output) and `pc_write`=1 advance the PC by 4.
- R4: Operand latches load every cycle from the register numbers in instruction bits 25:21 (first) and 20:16 (second). With `alu_src_b`=3 the second ALU operand is the sign-extended bits 15:0 shifted left by 2.
- R5: ALU function codes are 000 AND, 001 OR, 010 add, 110 subtract and 111 signed set-less-than (result 1 or 0). `zero` is 1 exactly when the ALU output is 0.
- R6: `alu_src_a`=1 selects the first operand latch. `alu_src_b`=2 selects the sign-extended bits 15:0. When `i_or_d`=1, `mem_addr` is the ALU result latch and `mem_wdata` is the second operand latch.
- R7: The memory data latch loads `mem_rdata` every cycle. With `reg_dst`=0, `mem_to_reg`=1 and `reg_write`=1, it is written to the register named by instruction bits 20:16.
- R8: With `reg_dst`=1, `mem_to_reg`=0 and `reg_write`=1, the ALU result latch is written to the register named by instruction bits 15:11.
- R9: When `pc_write_cond`=1 and `pc_source`=1, the PC loads the ALU result latch if `zero`=1 and is left unchanged otherwise.
- R10: When `pc_write`=1 and `pc_source`=2, the PC becomes its own top 4 bits followed by instruction bits 25:0 and two zero bits.
- R11: Register 0 reads as zero and discards writes.
- R12: The PC changes only when `pc_write`=1, or when `pc_write_cond`=1 and `zero`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pc_write | input | 1 | Unconditional PC load |
| pc_write_cond | input | 1 | PC load when the ALU result is zero |
| i_or_d | input | 1 | Memory address select: 0 = PC, 1 = ALU result latch |
| ir_write | input | 1 | Instruction latch load enable |
| mem_write | input | 1 | Memory write request |
| reg_write | input | 1 | Register file write enable |
| reg_dst | input | 1 | Destination select: 0 = bits 20:16, 1 = bits 15:11 |
| mem_to_reg | input | 1 | Write data select: 0 = ALU result latch, 1 = memory data latch |
| alu_src_a | input | 1 | First ALU operand: 0 = PC, 1 = first operand latch |
| alu_src_b | input | 2 | Second ALU operand: 0 latch, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_fn | input | 3 | ALU function code |
| pc_source | input | 2 | Next PC: 0 ALU output, 1 ALU result latch, 2 jump address |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle as the address |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU output equals zero |

## Verification
The register file and the hidden registers have no port of their own. Their contents show only during a store cycle, where the second operand latch appears on `mem_wdata` and the ALU result latch appears on `mem_addr`. Each arithmetic result, each loaded word and the discarded write to register 0 is therefore proven by a complete store instruction that the bench sequences afterwards. Branch decisions depend on register values that must first be loaded from memory, and the PC shows only on `mem_addr` during a fetch. The bench loads equal and unequal operands, runs both branch outcomes, and then reads the resulting PC from the address of the following fetch.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    OPB_REG  = 2'd0,
    OPB_FOUR = 2'd1,
    OPB_IMM  = 2'd2,
    OPB_IMM4 = 2'd3
  } opb_sel_e;

  typedef enum logic [1:0] {
    NPC_ALU    = 2'd0,
    NPC_ALUREG = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_sel_e;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   fn,
  output logic [W-1:0] res,
  output logic         is_zero
);

  always_comb begin
    case (alu_fn_e'(fn))
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ra1,
  input  logic [$clog2(N)-1:0] ra2,
  output logic [W-1:0]         rd1,
  output logic [W-1:0]         rd2
);

  localparam int AW = $clog2(N);

  logic [N-1:0][W-1:0] bank;

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_hardwired
      assign bank[g] = '0;
    end else begin : g_live
      logic         hit;
      logic [W-1:0] q;
      assign hit = we && (waddr == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata;
      end
      assign bank[g] = q;
    end
  end

  assign rd1 = bank[ra1];
  assign rd2 = bank[ra2];

  // A write to a nonzero register is visible on the next cycle
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr != '0)) |=> (bank[$past(waddr)] == $past(wdata)));

  // Register 0 still reads zero after a write aimed at it
  assert_zero_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr == '0)) |=> (bank[0] == '0));

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_write,
  input  logic            pc_write_cond,
  input  logic            i_or_d,
  input  logic            ir_write,
  input  logic            mem_write,
  input  logic            reg_write,
  input  logic            reg_dst,
  input  logic            mem_to_reg,
  input  logic            alu_src_a,
  input  logic [1:0]      alu_src_b,
  input  logic [2:0]      alu_fn,
  input  logic [1:0]      pc_source,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            zero
);

  localparam int RAW = $clog2(NREG);
  localparam int IMM = 16;
  localparam int JMP = 26;

  // reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // hidden and visible state
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] pc_d, ir_d, mdr_d, a_d, b_d, aluout_d;
  logic            pc_en;

  // instruction fields
  logic [RAW-1:0]  rs_f, rt_f, rd_f, wsel;
  logic [XLEN-1:0] imm_sx, imm_sx4, jump_tgt;

  assign rs_f     = ir_q[21 +: RAW];
  assign rt_f     = ir_q[16 +: RAW];
  assign rd_f     = ir_q[11 +: RAW];
  assign imm_sx   = {{(XLEN-IMM){ir_q[IMM-1]}}, ir_q[IMM-1:0]};
  assign imm_sx4  = {imm_sx[XLEN-3:0], 2'b00};
  assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[JMP-1:0], 2'b00};

  // register file
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wdata;

  assign wsel     = reg_dst ? rd_f : rt_f;
  assign rf_wdata = mem_to_reg ? mdr_q : aluout_q;

  mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (reg_write),
    .waddr (wsel),
    .wdata (rf_wdata),
    .ra1   (rs_f),
    .ra2   (rt_f),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2)
  );

  // shared ALU and its operand selection
  logic [XLEN-1:0] opa, opb, alu_y;
  logic            alu_z;

  assign opa = alu_src_a ? a_q : pc_q;

  always_comb begin
    case (opb_sel_e'(alu_src_b))
      OPB_REG:  opb = b_q;
      OPB_FOUR: opb = XLEN'(4);
      OPB_IMM:  opb = imm_sx;
      default:  opb = imm_sx4;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .opa     (opa),
    .opb     (opb),
    .fn      (alu_fn),
    .res     (alu_y),
    .is_zero (alu_z)
  );

  // next-state logic
  always_comb begin
    pc_en    = pc_write | (pc_write_cond & alu_z);
    case (npc_sel_e'(pc_source))
      NPC_ALUREG: pc_d = aluout_q;
      NPC_JUMP:   pc_d = jump_tgt;
      default:    pc_d = alu_y;
    endcase
    ir_d     = mem_rdata;
    mdr_d    = mem_rdata;
    a_d      = rf_rd1;
    b_d      = rf_rd2;
    aluout_d = alu_y;
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)    pc_q <= pc_d;
      if (ir_write) ir_q <= ir_d;
      mdr_q    <= mdr_d;
      a_q      <= a_d;
      b_q      <= b_d;
      aluout_q <= aluout_d;
    end
  end

  // outputs
  assign mem_addr  = i_or_d ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = mem_write & rst_sync_n;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];
  assign zero      = alu_z;

  // assertions
  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ir_write |=> $stable(ir_q));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_write && pc_source == 2'd0 && !alu_src_a && alu_src_b == 2'd1 && alu_fn == 3'b010)
    |=> (pc_q == $past(pc_q) + XLEN'(4)));

  assert_branch_taken_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pc_write && pc_write_cond && pc_source == 2'd1 && zero) |=> (pc_q == $past(aluout_q)));

  assert_jump_region_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_write && pc_source == 2'd2)
    |=> (pc_q[1:0] == 2'b00 && pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4])));

  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pc_write && !(pc_write_cond && zero)) |=> $stable(pc_q));

endmodule

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_write, pc_write_cond, i_or_d, ir_write, mem_write;
  logic        reg_write, reg_dst, mem_to_reg, alu_src_a;
  logic [1:0]  alu_src_b, pc_source;
  logic [2:0]  alu_fn;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, zero;
  logic [5:0]  opcode, funct;

  always #10 clk = ~clk;

  mc_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
    .i_or_d(i_or_d), .ir_write(ir_write), .mem_write(mem_write), .reg_write(reg_write),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .alu_fn(alu_fn), .pc_source(pc_source),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .opcode(opcode), .funct(funct), .zero(zero)
  );

  // bench memory: 256 words, read in the same cycle, written on the edge
  logic [31:0] mem [0:255];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;

  always @(posedge clk) begin
    if (tb_we)       mem[tb_wa] <= tb_wd;
    else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr[9:2]];

  int          checks = 0;
  int          errors = 0;
  logic [31:0] exp_pc = '0;

  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04, OP_J = 6'h02;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_ctl();
    pc_write = 0; pc_write_cond = 0; i_or_d = 0; ir_write = 0; mem_write = 0;
    reg_write = 0; reg_dst = 0; mem_to_reg = 0; alu_src_a = 0;
    alu_src_b = 2'd0; alu_fn = 3'b000; pc_source = 2'd0;
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    idle_ctl();
    tb_we = 1'b1; tb_wa = byte_addr[9:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // fetch step: R2 and R3 checked on every instruction
  task automatic fetch(input logic [31:0] instr);
    poke(exp_pc, instr);
    idle_ctl();
    ir_write = 1; pc_write = 1; alu_src_b = 2'd1; alu_fn = 3'b010;
    #1 chk("R3 fetch address", mem_addr, exp_pc);
    @(negedge clk);
    exp_pc = exp_pc + 32'd4;
    chk("R2 opcode", {26'b0, opcode}, {26'b0, instr[31:26]});
    chk("R2 funct", {26'b0, funct}, {26'b0, instr[5:0]});
  endtask

  task automatic decode();
    idle_ctl();
    alu_src_b = 2'd3; alu_fn = 3'b010;
    @(negedge clk);
  endtask

  task automatic addr_calc();
    idle_ctl();
    alu_src_a = 1; alu_src_b = 2'd2; alu_fn = 3'b010;
    @(negedge clk);
  endtask

  task automatic t_load(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                        input logic [31:0] exp_addr);
    fetch({OP_LW, rs, rt, imm});
    decode();
    addr_calc();
    idle_ctl(); i_or_d = 1;
    #1 chk("R6 load address", mem_addr, exp_addr);
    @(negedge clk);
    idle_ctl(); mem_to_reg = 1; reg_write = 1;     // R7 write-back to rt
    @(negedge clk);
    idle_ctl();
  endtask

  task automatic t_store(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                         input logic [31:0] exp_addr, input logic [31:0] exp_data,
                         input string req);
    fetch({OP_SW, rs, rt, imm});
    decode();
    addr_calc();
    idle_ctl(); i_or_d = 1; mem_write = 1;
    #1;
    chk("R6 store address", mem_addr, exp_addr);
    chk(req, mem_wdata, exp_data);
    chk("R6 write strobe", {31'b0, mem_we}, 32'd1);
    @(negedge clk);
    idle_ctl();
  endtask

  task automatic t_rtype(input logic [2:0] fn, input logic [5:0] fcode,
                         input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
    fetch({OP_R, rs, rt, rd, 5'd0, fcode});
    decode();
    idle_ctl(); alu_src_a = 1; alu_src_b = 2'd0; alu_fn = fn;
    @(negedge clk);
    idle_ctl(); reg_dst = 1; reg_write = 1;        // R8 write-back to rd
    @(negedge clk);
    idle_ctl();
  endtask

  task automatic t_branch(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off,
                          input logic exp_zero);
    logic [31:0] target;
    fetch({OP_BEQ, rs, rt, off});
    decode();
    target = exp_pc + {{14{off[15]}}, off, 2'b00};
    idle_ctl(); alu_src_a = 1; alu_src_b = 2'd0; alu_fn = 3'b110;
    pc_write_cond = 1; pc_source = 2'd1;
    #1 chk("R9 zero flag on compare", {31'b0, zero}, {31'b0, exp_zero});
    @(negedge clk);
    if (exp_zero) exp_pc = target;
    idle_ctl();
    #1 chk(exp_zero ? "R9 branch taken PC" : "R12 branch not taken PC", mem_addr, exp_pc);
  endtask

  task automatic t_jump(input logic [25:0] tgt);
    fetch({OP_J, tgt});
    decode();
    idle_ctl(); pc_write = 1; pc_source = 2'd2;
    @(negedge clk);
    exp_pc = {exp_pc[31:28], tgt, 2'b00};
    idle_ctl();
    #1 chk("R10 jump PC", mem_addr, exp_pc);
  endtask

  task automatic t_ir_hold(input logic [31:0] held);
    poke(exp_pc, 32'hFC00_003F);
    #1;
    chk("R2 opcode held without ir_write", {26'b0, opcode}, {26'b0, held[31:26]});
    chk("R2 funct held without ir_write", {26'b0, funct}, {26'b0, held[5:0]});
  endtask

  task automatic t_reset();
    idle_ctl();
    #1;
    chk("R1 reset PC on address", mem_addr, 32'd0);
    chk("R1 reset opcode", {26'b0, opcode}, 32'd0);
    chk("R1 reset funct", {26'b0, funct}, 32'd0);
    chk("R1 reset operand latch", mem_wdata, 32'd0);
    chk("R1 reset strobe", {31'b0, mem_we}, 32'd0);
    chk("R1 reset zero flag", {31'b0, zero}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_ctl();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();

    poke(32'h100, 32'h1234_5678);
    poke(32'h104, 32'hFFFF_FFF0);
    poke(32'h108, 32'h0000_0007);
    poke(32'h10C, 32'h0000_0120);

    t_load(5'd1, 5'd0, 16'h0100, 32'h100);
    t_load(5'd2, 5'd0, 16'h0104, 32'h104);
    t_load(5'd3, 5'd0, 16'h0108, 32'h108);
    t_load(5'd10, 5'd0, 16'h010C, 32'h10C);
    t_store(5'd1, 5'd0, 16'h0110, 32'h110, 32'h1234_5678, "R7 loaded word");

    t_rtype(3'b010, 6'h20, 5'd4, 5'd1, 5'd3);
    t_store(5'd4, 5'd0, 16'h0114, 32'h114, 32'h1234_567F, "R8 add result");
    t_rtype(3'b110, 6'h22, 5'd5, 5'd3, 5'd2);
    t_store(5'd5, 5'd0, 16'h0114, 32'h114, 32'h0000_0017, "R5 subtract");
    t_rtype(3'b111, 6'h2A, 5'd6, 5'd2, 5'd3);
    t_store(5'd6, 5'd0, 16'h0114, 32'h114, 32'h0000_0001, "R5 signed less-than");
    t_rtype(3'b000, 6'h24, 5'd7, 5'd1, 5'd2);
    t_store(5'd7, 5'd0, 16'h0114, 32'h114, 32'h1234_5670, "R5 and");
    t_rtype(3'b001, 6'h25, 5'd8, 5'd1, 5'd3);
    t_store(5'd8, 5'd0, 16'h0114, 32'h114, 32'h1234_567F, "R5 or");

    t_store(5'd3, 5'd10, 16'hFFF8, 32'h118, 32'h0000_0007, "R6 negative offset data");

    t_rtype(3'b010, 6'h20, 5'd0, 5'd1, 5'd3);
    t_store(5'd0, 5'd0, 16'h011C, 32'h11C, 32'h0000_0000, "R11 register 0 after write");

    t_branch(5'd1, 5'd1, 16'd3, 1'b1);   // R4 target from decode step
    t_branch(5'd1, 5'd3, 16'd3, 1'b0);
    t_jump(26'h30);
    t_ir_hold({OP_J, 26'h30});
    t_store(5'd4, 5'd0, 16'h0110, 32'h110, 32'h1234_567F, "R3 fetch after jump");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule